// File: doc/BRIEF.md
# Multichannel DAC Code Register Bank

This block keeps the digital side of a twelve-channel converter: one 8-bit code per channel, and, for the eight pins that can serve either as an analog output or as a general digital pin (channels 5 to 12), a flag saying whether the pin is currently in analog mode. The resistor ladders, amplifiers and pin drivers sit elsewhere; this bank only supplies them with codes and enables.

It receives an already deserialised 16-bit command word and a single-cycle execute strobe, both synchronous to the system clock. The low nibble of the word names a target, the next nibble names an operation, and the top byte carries a code. Besides plain per-channel writes, a special target (select 0) offers a broadcast of one code to every channel, a release of all shared pins back to digital use, and a full return to the power-on state. Selects 13 to 15 belong to the digital expander, which is handled by other logic, and leave this bank untouched.

Top module: `dac_code_bank`

## Requirements
- R1: The target is taken from word bits 3..0; values 1 to 12 address channels 1 to 12, value 0 is the group target, and values 13, 14, 15 change no output of this block.
- R2: With a channel target and operation bits 7..4 = 0000, the code in bits 15..8 is stored for that channel and, for channels 5 to 12, the channel's analog enable is set.
- R3: With a channel target and operation 0001, channels 5 to 12 clear their analog enable and keep their code; on channels 1 to 4 the operation changes nothing.
- R4: With a channel target, operations 0010 to 1111 change nothing.
- R5: With target 0 and operation 1100, the code in bits 15..8 is stored in all twelve channels; analog enables are unchanged.
- R6: With target 0 and operation 1101, the analog enables of channels 5 to 12 are all cleared; codes are unchanged.
- R7: With target 0 and operation 1110, every code returns to 0 and every shared-pin analog enable is cleared.
- R8: With target 0, operations 0000 to 1011 and 1111 change nothing.
- R9: While the synchronous active-high reset is sampled high, all codes become 0 and `ana_en` becomes 12'h00F.
- R10: A command word presented without the execute strobe changes nothing.
- R11: `ana_en` bits 3..0 are always 1; bit k for k = 4..11 is the analog enable of channel k+1.
- R12: A command takes effect at the clock edge that samples the strobe and is visible on the outputs right after that edge; channel k's code sits at `dac_codes` bits 8(k-1)+7 .. 8(k-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_word | input | 16 | Command: code [15:8], operation [7:4], target [3:0] |
| cmd_exec | input | 1 | Single-cycle strobe that executes `cmd_word` |
| dac_codes | output | 96 | Twelve 8-bit codes, channel 1 in the lowest byte |
| ana_en | output | 12 | Analog enable per channel, bit 0 = channel 1 |

## Verification
The hardest state to reach is a mix in which the codes and the shared-pin enables have drifted apart: a broadcast lands over codes that differ, then a single write overrides exactly one channel, while some shared pins have been released and others not. The stimulus builds that state step by step (distinct per-channel loads, a release of one shared pin, a broadcast, one overriding write) so that each later check shows the group operations touched only the state they own. The ignored encodings, strobeless words and expander selects are placed between these steps, where a wrongly decoded command would visibly disturb a known non-zero state.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int NCH         = 12;
    localparam int CODE_W      = 8;
    localparam int SEL_W       = 4;
    localparam int OP_W        = 4;
    localparam int WORD_W      = SEL_W + OP_W + CODE_W;
    localparam int SEL_LSB     = 0;
    localparam int OP_LSB      = SEL_LSB + SEL_W;
    localparam int CODE_LSB    = OP_LSB + OP_W;
    localparam int SHARED_BASE = 4;
    localparam int N_SHARED    = NCH - SHARED_BASE;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 4'b0000,
        OP_RELEASE = 4'b0001
    } chan_op_e;

    typedef enum logic [OP_W-1:0] {
        GOP_BCAST  = 4'b1100,
        GOP_RELALL = 4'b1101,
        GOP_RESET  = 4'b1110
    } group_op_e;

    typedef struct packed {
        logic              ld_one;
        logic              rel_one;
        logic              ld_all;
        logic              rel_all;
        logic              clr_all;
        logic [NCH-1:0]    ch_hot;
        logic [CODE_W-1:0] code;
    } dcb_action_t;

    function automatic logic sel_is_channel(input logic [SEL_W-1:0] sel);
        return (sel != '0) && (int'(sel) <= NCH);
    endfunction
endpackage

// File: rtl/dcb_cmd_decode.sv
module dcb_cmd_decode
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              exec,
    output dcb_action_t       act
);
    logic [SEL_W-1:0] sel;
    logic [OP_W-1:0]  op;

    assign sel = word[SEL_LSB +: SEL_W];
    assign op  = word[OP_LSB +: OP_W];

    always_comb begin
        act      = '0;
        act.code = word[CODE_LSB +: CODE_W];
        if (exec) begin
            if (sel == '0) begin
                case (op)
                    GOP_BCAST:  act.ld_all  = 1'b1;
                    GOP_RELALL: act.rel_all = 1'b1;
                    GOP_RESET:  act.clr_all = 1'b1;
                    default:    ;
                endcase
            end else if (sel_is_channel(sel)) begin
                for (int i = 0; i < NCH; i++)
                    act.ch_hot[i] = (sel == SEL_W'(i + 1));
                case (op)
                    OP_LOAD:    act.ld_one  = 1'b1;
                    OP_RELEASE: act.rel_one = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    // R1: a decoded word never addresses more than one channel
    p_single_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act.ch_hot));
    // R1: at most one action kind per word
    p_one_action_r1: assert property (@(posedge clk) disable iff (rst)
        $countones({act.ld_one, act.rel_one, act.ld_all, act.rel_all, act.clr_all}) <= 1);
    // R10: no strobe, no action
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !exec |-> !(act.ld_one || act.rel_one || act.ld_all || act.rel_all || act.clr_all));
endmodule

// File: rtl/dcb_code_bank.sv
module dcb_code_bank
    import dcb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ld_one,
    input  logic                       ld_all,
    input  logic                       clr_all,
    input  logic [NCH-1:0]             ch_hot,
    input  logic [CODE_W-1:0]          code,
    output logic [NCH-1:0][CODE_W-1:0] codes_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst || clr_all)
                codes_q[i] <= '0;
            else if (ld_all || (ld_one && ch_hot[i]))
                codes_q[i] <= code;
        end

        // R5: broadcast reaches every channel
        p_bcast_r5: assert property (@(posedge clk) disable iff (rst)
            (ld_all && !clr_all) |=> codes_q[i] == $past(code));
        // R2: addressed load stores the code
        p_load_r2: assert property (@(posedge clk) disable iff (rst)
            (ld_one && ch_hot[i]) |=> codes_q[i] == $past(code));
    end

    // R7: group reset clears all codes
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> codes_q == '0);
    // R10: codes hold without a writing action
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ld_one || ld_all || clr_all) |=> $stable(codes_q));
endmodule

// File: rtl/dcb_mode_flags.sv
module dcb_mode_flags
    import dcb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_one,
    input  logic                rel_one,
    input  logic                rel_all,
    input  logic                clr_all,
    input  logic [N_SHARED-1:0] sh_hot,
    output logic [N_SHARED-1:0] analog_q
);
    for (genvar j = 0; j < N_SHARED; j++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst || clr_all || rel_all)
                analog_q[j] <= 1'b0;
            else if (sh_hot[j] && ld_one)
                analog_q[j] <= 1'b1;
            else if (sh_hot[j] && rel_one)
                analog_q[j] <= 1'b0;
        end

        // R2: a load on a shared channel turns its pin analog
        p_load_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (ld_one && sh_hot[j] && !clr_all && !rel_all) |=> analog_q[j]);
        // R3: a release on a shared channel hands the pin back
        p_release_r3: assert property (@(posedge clk) disable iff (rst)
            (rel_one && sh_hot[j]) |=> !analog_q[j]);
    end

    // R6: releasing all pins clears every flag
    p_rel_all_r6: assert property (@(posedge clk) disable iff (rst)
        (rel_all || clr_all) |=> analog_q == '0);
    // R10: flags hold when no mode action is decoded
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ld_one || rel_one || rel_all || clr_all) |=> $stable(analog_q));
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
    import dcb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     cmd_word,
    input  logic                  cmd_exec,
    output logic [NCH*CODE_W-1:0] dac_codes,
    output logic [NCH-1:0]        ana_en
);
    dcb_action_t                act;
    logic [NCH-1:0][CODE_W-1:0] codes_q;
    logic [N_SHARED-1:0]        analog_q;

    dcb_cmd_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .word (cmd_word),
        .exec (cmd_exec),
        .act  (act)
    );

    dcb_code_bank u_codes (
        .clk     (clk),
        .rst     (rst),
        .ld_one  (act.ld_one),
        .ld_all  (act.ld_all),
        .clr_all (act.clr_all),
        .ch_hot  (act.ch_hot),
        .code    (act.code),
        .codes_q (codes_q)
    );

    dcb_mode_flags u_modes (
        .clk      (clk),
        .rst      (rst),
        .ld_one   (act.ld_one),
        .rel_one  (act.rel_one),
        .rel_all  (act.rel_all),
        .clr_all  (act.clr_all),
        .sh_hot   (act.ch_hot[NCH-1:SHARED_BASE]),
        .analog_q (analog_q)
    );

    assign dac_codes = codes_q;
    assign ana_en    = {analog_q, {SHARED_BASE{1'b1}}};

    // R11: dedicated channels always report analog mode
    p_dedicated_on_r11: assert property (@(posedge clk) disable iff (rst)
        ana_en[SHARED_BASE-1:0] == '1);
    // R9: reset returns the power-on state
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (dac_codes == '0 && ana_en == NCH'((1 << SHARED_BASE) - 1)));
    // R1: expander selects leave all outputs alone
    p_expander_sel_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_exec && cmd_word[3:0] >= 4'd13) |=> ($stable(dac_codes) && $stable(ana_en)));
endmodule

// File: tb/dac_code_bank_tb_top.sv
module dac_code_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_exec = 1'b0;
    logic [95:0] dac_codes;
    logic [11:0] ana_en;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [95:0] codes;
        logic [11:0] en;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    logic [7:0] m_code [12];
    logic [7:0] m_flag;

    always #5 clk = ~clk;

    dac_code_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_word  (cmd_word),
        .cmd_exec  (cmd_exec),
        .dac_codes (dac_codes),
        .ana_en    (ana_en)
    );

    function automatic exp_t snapshot(string tag);
        exp_t e;
        for (int i = 0; i < 12; i++) e.codes[i*8 +: 8] = m_code[i];
        e.en  = {m_flag, 4'hF};
        e.tag = tag;
        return e;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 12; i++) m_code[i] = 8'h00;
        m_flag = 8'h00;
    endfunction

    // Reference behaviour built from the requirements
    function automatic void model_cmd(logic [15:0] w);
        logic [3:0] sel;
        logic [3:0] op;
        logic [7:0] c;
        sel = w[3:0];
        op  = w[7:4];
        c   = w[15:8];
        if (sel == 4'd0) begin
            if (op == 4'b1100) for (int i = 0; i < 12; i++) m_code[i] = c;
            else if (op == 4'b1101) m_flag = 8'h00;
            else if (op == 4'b1110) model_reset();
        end else if (sel <= 4'd12) begin
            if (op == 4'b0000) begin
                m_code[sel-1] = c;
                if (sel >= 4'd5) m_flag[sel-5] = 1'b1;
            end else if (op == 4'b0001) begin
                if (sel >= 4'd5) m_flag[sel-5] = 1'b0;
            end
        end
    endfunction

    task automatic send(input logic [15:0] w, input logic strobe, input string tag);
        @(negedge clk);
        cmd_word = w;
        cmd_exec = strobe;
        @(posedge clk);
        #1;
        cmd_exec = 1'b0;
        if (strobe) model_cmd(w);
        exp_q.push_back(snapshot(tag));
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        exp_q.push_back(snapshot(tag));
    endtask

    function automatic logic [15:0] mk(logic [7:0] c, logic [3:0] op, logic [3:0] sel);
        return {c, op, sel};
    endfunction

    // Monitor: compare outputs away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dac_codes !== e.codes) begin
                    fails++;
                    $display("FAIL %s codes: actual %h expected %h", e.tag, dac_codes, e.codes);
                end
                checks++;
                if (ana_en !== e.en) begin
                    fails++;
                    $display("FAIL %s ana_en: actual %h expected %h", e.tag, ana_en, e.en);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        do_reset("R9 reset state");
        send(mk(8'h5A, 4'b0000, 4'd1),  1'b1, "R2 R12 load ch1");
        send(mk(8'h33, 4'b0000, 4'd5),  1'b1, "R2 R11 load ch5 sets enable");
        send(mk(8'hFF, 4'b0000, 4'd12), 1'b1, "R2 load ch12");
        send(mk(8'h81, 4'b0000, 4'd8),  1'b1, "R2 load ch8");
        send(mk(8'h00, 4'b0001, 4'd5),  1'b1, "R3 release ch5 keeps code");
        send(mk(8'h00, 4'b0001, 4'd2),  1'b1, "R3 release on dedicated ch2");
        send(mk(8'h77, 4'b0111, 4'd3),  1'b1, "R4 ignored op on ch3");
        send(mk(8'h99, 4'b1111, 4'd8),  1'b1, "R4 ignored op on ch8");
        send(mk(8'h11, 4'b0000, 4'd13), 1'b1, "R1 select 13 ignored");
        send(mk(8'h22, 4'b0000, 4'd14), 1'b1, "R1 select 14 ignored");
        send(mk(8'h44, 4'b1100, 4'd15), 1'b1, "R1 select 15 ignored");
        send(mk(8'hEE, 4'b0000, 4'd4),  1'b0, "R10 no strobe");
        send(mk(8'hEE, 4'b1110, 4'd0),  1'b0, "R10 no strobe reset word");
        send(mk(8'hA5, 4'b1100, 4'd0),  1'b1, "R5 broadcast");
        send(mk(8'h3C, 4'b0000, 4'd7),  1'b1, "R2 R5 override ch7 after broadcast");
        send(mk(8'h00, 4'b0000, 4'd0),  1'b1, "R8 group op 0000 ignored");
        send(mk(8'h12, 4'b1011, 4'd0),  1'b1, "R8 group op 1011 ignored");
        send(mk(8'h34, 4'b1111, 4'd0),  1'b1, "R8 group op 1111 ignored");
        send(mk(8'h01, 4'b0000, 4'd9),  1'b1, "R2 load ch9");
        send(mk(8'h00, 4'b1101, 4'd0),  1'b1, "R6 release all keeps codes");
        send(mk(8'h00, 4'b0001, 4'd9),  1'b1, "R3 release already released");
        send(mk(8'h6B, 4'b0000, 4'd11), 1'b1, "R2 load ch11");
        send(mk(8'hC3, 4'b0000, 4'd6),  1'b1, "R2 load ch6");
        send(mk(8'hFF, 4'b1110, 4'd0),  1'b1, "R7 group reset");
        send(mk(8'h42, 4'b0000, 4'd10), 1'b1, "R2 load after group reset");
        send(mk(8'h00, 4'b1100, 4'd0),  1'b1, "R5 broadcast zero");
        send(mk(8'h9E, 4'b0000, 4'd12), 1'b1, "R2 load ch12 again");
        do_reset("R9 reset from busy state");
        send(mk(8'h00, 4'b0000, 4'd0),  1'b0, "R9 R11 idle after reset");
        wait (exp_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule